// File: doc/BRIEF.md
# Bridge Primary-Side Window Decoder

This block holds three base address registers on the primary side of a non-transparent bridge and classifies each incoming request against them. The memory BAR covers one power-of-two window. Its lowest 4 KB select the bridge's internal registers, and the rest of the window forwards traffic to the far side. A 256-byte I/O BAR also reaches the internal registers. An expansion ROM BAR has a size chosen by a setup code between 4 KB and 16 MB, and the same code can remove the ROM window altogether.

Configuration software writes all ones to a BAR and reads it back to learn the BAR's size and type, then writes a base address. Each request carries an address, a space flag and a valid strobe. One cycle later the block reports one of four results: a register hit, a forward hit, a ROM hit, or no hit. On a hit it also gives the offset inside the matched window. Configuration bus timing, register contents and the forwarding data path belong to other blocks.

Top module: `ntb_win_decode`

## Requirements
- R1: After reset, the memory BAR reads 0x00000000, the I/O BAR reads 0x00000001 and the ROM BAR reads 0x00000000, and all three hit outputs are low. The select code `cfg_sel` is 0 for the memory BAR, 1 for the I/O BAR and 2 for the ROM BAR; code 3 reads zero and ignores writes.
- R2: The memory window size is 2^L bytes. L is `fwd_log2` when that value is 12 or more, and 12 otherwise. After all ones are written, the memory BAR reads back ones in bits 31..L and zeros below bit L. Bits 3..0 are always 0, which marks a 32-bit non-prefetchable memory BAR.
- R3: After all ones are written, the I/O BAR reads back 0xFFFFFF01. Bit 0 set marks I/O space, and bits 7..1 read zero.
- R4: A ROM setup code c from 1 to 13 gives a ROM window of 2^(11+c) bytes. After all ones are written, the ROM BAR reads ones in bits 31..(11+c), with the written enable in bit 0 and zeros elsewhere.
- R5: A ROM setup code of 0, 14 or 15 removes the ROM window. The ROM BAR then reads 0x00000000 and `rom_hit` never goes high.
- R6: A memory request inside the memory window whose window offset is below 0x1000 gives `reg_hit`, and `hit_off` carries that offset.
- R7: A memory request inside the memory window whose window offset is 0x1000 or more gives `fwd_hit`, and `hit_off` carries the full window offset.
- R8: An I/O request whose bits 31..8 equal the I/O BAR base gives `reg_hit`, and `hit_off` carries address bits 7..0.
- R9: A memory request inside the ROM window gives `rom_hit` with the window offset. This happens only when ROM BAR bit 0 is set and the window is present.
- R10: While `mem_en` is low, memory requests produce no hit. While `io_en` is low, I/O requests produce no hit.
- R11: At most one hit output is high at a time. Where the memory and ROM windows overlap, the memory BAR wins.
- R12: Results appear in the cycle after `req_valid`. When `req_valid` was low, or when nothing matched, every hit output is low and `hit_off` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the BAR chosen by cfg_sel |
| cfg_sel | input | 2 | BAR select: 0 memory, 1 I/O, 2 ROM, 3 none |
| cfg_wdata | input | 32 | BAR write data |
| cfg_rdata | output | 32 | Read-back of the selected BAR (combinational) |
| fwd_log2 | input | 5 | Log2 of the memory window size (raised to 12 if lower) |
| rom_code | input | 4 | ROM setup code: 1..13 sets the size, other values remove the window |
| mem_en | input | 1 | Memory space decode enable |
| io_en | input | 1 | I/O space decode enable |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | Request targets I/O space when high, memory space when low |
| req_addr | input | 32 | Request address |
| reg_hit | output | 1 | Registered: internal register hit |
| fwd_hit | output | 1 | Registered: forwarding region hit |
| rom_hit | output | 1 | Registered: expansion ROM hit |
| hit_off | output | 32 | Registered: offset inside the matched window |

## Verification
A stored base or size mask that has been corrupted shows up at the ports in two places. It appears right away in the combinational read-back of the selected BAR. It also appears one cycle after the first request near the window, as a wrong outcome or a wrong offset. A bad boundary between the register and forwarding regions can only be seen with requests near offset 0x1000, so the tests place addresses on both sides of that boundary. A ROM setup code decoded wrongly shows up as a read-back mask in the wrong place, or as a ROM hit when the window should be absent. The tests therefore cover the smallest and largest codes as well as the codes that remove the window.

// File: rtl/ntb_dec_pkg.sv
package ntb_dec_pkg;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'd0,
    SEL_IO   = 2'd1,
    SEL_ROM  = 2'd2,
    SEL_NONE = 2'd3
  } bar_sel_e;

  // Ones in every bit at or above lg, zeros below.
  function automatic logic [31:0] upper_mask(input logic [5:0] lg);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      m[i] = (6'(i) >= lg);
    end
    return m;
  endfunction

  // Raise a requested window exponent to the minimum.
  function automatic logic [5:0] clamp_log2(input logic [4:0] req, input logic [5:0] floor_lg);
    return ({1'b0, req} < floor_lg) ? floor_lg : {1'b0, req};
  endfunction

  // ROM setup code to window exponent; valid only when code_live holds.
  function automatic logic [5:0] rom_log2(input logic [3:0] code, input logic [5:0] base_lg);
    return base_lg + {2'b00, code};
  endfunction

  function automatic logic code_live(input logic [3:0] code, input logic [3:0] max_code);
    return (code != 4'd0) && (code <= max_code);
  endfunction

endpackage

// File: rtl/ntb_bar_reg.sv
module ntb_bar_reg #(
  parameter int AW = 32,
  parameter logic [AW-1:0] TYPE_BITS = '0,
  parameter bit HAS_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] size_mask,
  output logic [AW-1:0] base,
  output logic          en,
  output logic [AW-1:0] rdata
);

  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (wr) base_q <= wdata;
  end

  assign base = base_q & size_mask;

  generate
    if (HAS_EN) begin : g_en
      logic en_q;
      always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else if (wr) en_q <= wdata[0];
      end
      assign en    = en_q;
      assign rdata = base | TYPE_BITS | {{(AW-1){1'b0}}, en_q};
    end else begin : g_noen
      assign en    = 1'b1;
      assign rdata = base | TYPE_BITS;
    end
  endgenerate

endmodule

// File: rtl/ntb_win_match.sv
module ntb_win_match #(
  parameter int AW = 32
) (
  input  logic          gate,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size_mask,
  output logic          hit,
  output logic [AW-1:0] off
);

  assign hit = gate && ((addr & size_mask) == (base & size_mask));
  assign off = addr & ~size_mask;

endmodule

// File: rtl/ntb_win_decode.sv
module ntb_win_decode
  import ntb_dec_pkg::*;
#(
  parameter int AW           = 32,
  parameter int REG_LOG2     = 12,
  parameter int IO_LOG2      = 8,
  parameter int ROM_MIN_LOG2 = 12,
  parameter int ROM_MAX_CODE = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [4:0]    fwd_log2,
  input  logic [3:0]    rom_code,
  input  logic          mem_en,
  input  logic          io_en,
  input  logic          req_valid,
  input  logic          req_is_io,
  input  logic [31:0]   req_addr,
  output logic          reg_hit,
  output logic          fwd_hit,
  output logic          rom_hit,
  output logic [31:0]   hit_off
);

  localparam logic [5:0]  REG_LG    = 6'(REG_LOG2);
  localparam logic [5:0]  IO_LG     = 6'(IO_LOG2);
  localparam logic [5:0]  ROM_BASE  = 6'(ROM_MIN_LOG2 - 1);
  localparam logic [3:0]  ROM_TOP   = 4'(ROM_MAX_CODE);
  localparam logic [31:0] REG_SPAN  = 32'(1) << REG_LOG2;
  localparam logic [31:0] MEM_TYPE  = 32'h0;
  localparam logic [31:0] IO_TYPE   = 32'h1;

  // Window geometry
  logic [5:0]  mem_lg, rom_lg;
  logic [31:0] mem_mask, io_mask, rom_mask;
  logic        rom_live;

  assign mem_lg   = clamp_log2(fwd_log2, REG_LG);
  assign rom_lg   = rom_log2(rom_code, ROM_BASE);
  assign rom_live = code_live(rom_code, ROM_TOP);
  assign mem_mask = upper_mask(mem_lg);
  assign io_mask  = upper_mask(IO_LG);
  assign rom_mask = rom_live ? upper_mask(rom_lg) : 32'h0;

  // BAR registers
  logic        wr_mem, wr_io, wr_rom;
  logic [31:0] mem_base, io_base, rom_base;
  logic [31:0] mem_rd, io_rd, rom_rd;
  logic        mem_en_unused, io_en_unused, rom_bar_en;

  assign wr_mem = cfg_wr && (bar_sel_e'(cfg_sel) == SEL_MEM);
  assign wr_io  = cfg_wr && (bar_sel_e'(cfg_sel) == SEL_IO);
  assign wr_rom = cfg_wr && (bar_sel_e'(cfg_sel) == SEL_ROM);

  ntb_bar_reg #(.AW(32), .TYPE_BITS(MEM_TYPE), .HAS_EN(1'b0)) u_mem_bar (
    .clk(clk), .rst_n(rst_n), .wr(wr_mem), .wdata(cfg_wdata), .size_mask(mem_mask),
    .base(mem_base), .en(mem_en_unused), .rdata(mem_rd)
  );

  ntb_bar_reg #(.AW(32), .TYPE_BITS(IO_TYPE), .HAS_EN(1'b0)) u_io_bar (
    .clk(clk), .rst_n(rst_n), .wr(wr_io), .wdata(cfg_wdata), .size_mask(io_mask),
    .base(io_base), .en(io_en_unused), .rdata(io_rd)
  );

  ntb_bar_reg #(.AW(32), .TYPE_BITS(32'h0), .HAS_EN(1'b1)) u_rom_bar (
    .clk(clk), .rst_n(rst_n), .wr(wr_rom), .wdata(cfg_wdata), .size_mask(rom_mask),
    .base(rom_base), .en(rom_bar_en), .rdata(rom_rd)
  );

  always_comb begin
    unique case (bar_sel_e'(cfg_sel))
      SEL_MEM: cfg_rdata = mem_rd;
      SEL_IO:  cfg_rdata = io_rd;
      SEL_ROM: cfg_rdata = rom_live ? rom_rd : 32'h0;
      default: cfg_rdata = 32'h0;
    endcase
  end

  // Window matches, brought out for the checker
  logic        dec_mem_win, dec_io_win, dec_rom_win;
  logic [31:0] mem_off, io_off, rom_off;
  logic        mem_gate, io_gate, rom_gate;

  assign mem_gate = req_valid && !req_is_io && mem_en;
  assign io_gate  = req_valid && req_is_io && io_en;
  assign rom_gate = mem_gate && rom_live && rom_bar_en;

  ntb_win_match #(.AW(32)) u_mem_match (
    .gate(mem_gate), .addr(req_addr), .base(mem_base), .size_mask(mem_mask),
    .hit(dec_mem_win), .off(mem_off)
  );

  ntb_win_match #(.AW(32)) u_io_match (
    .gate(io_gate), .addr(req_addr), .base(io_base), .size_mask(io_mask),
    .hit(dec_io_win), .off(io_off)
  );

  ntb_win_match #(.AW(32)) u_rom_match (
    .gate(rom_gate), .addr(req_addr), .base(rom_base), .size_mask(rom_mask),
    .hit(dec_rom_win), .off(rom_off)
  );

  // Outcome selection: memory BAR, then I/O, then ROM
  logic        nx_reg, nx_fwd, nx_rom;
  logic [31:0] nx_off;

  always_comb begin
    nx_reg = 1'b0;
    nx_fwd = 1'b0;
    nx_rom = 1'b0;
    nx_off = 32'h0;
    if (dec_mem_win) begin
      if (mem_off < REG_SPAN) nx_reg = 1'b1;
      else                    nx_fwd = 1'b1;
      nx_off = mem_off;
    end else if (dec_io_win) begin
      nx_reg = 1'b1;
      nx_off = io_off;
    end else if (dec_rom_win) begin
      nx_rom = 1'b1;
      nx_off = rom_off;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_hit <= 1'b0;
      fwd_hit <= 1'b0;
      rom_hit <= 1'b0;
      hit_off <= 32'h0;
    end else begin
      reg_hit <= nx_reg;
      fwd_hit <= nx_fwd;
      rom_hit <= nx_rom;
      hit_off <= nx_off;
    end
  end

endmodule

// File: rtl/ntb_win_decode_chk.sv
module ntb_win_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic [3:0]  rom_code,
  input logic        mem_en,
  input logic        io_en,
  input logic        req_valid,
  input logic        req_is_io,
  input logic        reg_hit,
  input logic        fwd_hit,
  input logic        rom_hit,
  input logic [31:0] hit_off,
  input logic        dec_mem_win,
  input logic        dec_rom_win
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_hit, fwd_hit, rom_hit})); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!reg_hit && !fwd_hit && !rom_hit && hit_off == 32'h0)); // R12

  AST_MEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && !mem_en) |=> (!reg_hit && !fwd_hit && !rom_hit)); // R10

  AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && !io_en) |=> (!reg_hit && !fwd_hit && !rom_hit)); // R10

  AST_ROM_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_code == 4'd0 || rom_code > 4'd13) |=> !rom_hit); // R5

  AST_ROM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd2 && (rom_code == 4'd0 || rom_code > 4'd13)) |-> cfg_rdata == 32'h0); // R5

  AST_ROM_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mem_win && dec_rom_win) |=> !rom_hit); // R11

  AST_FWD_ABOVE_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> hit_off >= 32'h1000); // R7

endmodule

bind ntb_win_decode ntb_win_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
  .rom_code(rom_code), .mem_en(mem_en), .io_en(io_en), .req_valid(req_valid),
  .req_is_io(req_is_io), .reg_hit(reg_hit), .fwd_hit(fwd_hit), .rom_hit(rom_hit),
  .hit_off(hit_off), .dec_mem_win(dec_mem_win), .dec_rom_win(dec_rom_win)
);

// File: tb/ntb_win_decode_test.sv
`timescale 1ns/1ps
module ntb_win_decode_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [4:0]  fwd_log2 = 5'd16;
  logic [3:0]  rom_code = 4'd0;
  logic        mem_en = 1'b0;
  logic        io_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic        reg_hit, fwd_hit, rom_hit;
  logic [31:0] hit_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ntb_win_decode uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fwd_log2(fwd_log2), .rom_code(rom_code), .mem_en(mem_en),
    .io_en(io_en), .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
    .reg_hit(reg_hit), .fwd_hit(fwd_hit), .rom_hit(rom_hit), .hit_off(hit_off)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Ones from bit lg upward, built by shifting
  function automatic logic [31:0] hi_ones(input int lg);
    return 32'hFFFF_FFFF << lg;
  endfunction

  task automatic bar_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic bar_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  // Returns {reg,fwd,rom} and the offset seen one cycle after the strobe
  task automatic probe(input logic [31:0] a, input logic io, output logic [2:0] h,
                       output logic [31:0] o);
    @(negedge clk);
    req_addr = a; req_is_io = io; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    h = {reg_hit, fwd_hit, rom_hit};
    o = hit_off;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bar_read(2'd0, d); check("R1 mem bar reset", d, 32'h0);
    bar_read(2'd1, d); check("R1 io bar reset", d, 32'h1);
    rom_code = 4'd3;
    bar_read(2'd2, d); check("R1 rom bar reset", d, 32'h0);
    check("R1 hits low", {29'h0, reg_hit, fwd_hit, rom_hit}, 32'h0);
  endtask

  task automatic t_mem_sizing();
    logic [31:0] d;
    fwd_log2 = 5'd16;
    bar_write(2'd0, 32'hFFFF_FFFF);
    bar_read(2'd0, d); check("R2 mem size 64K", d, hi_ones(16));
    fwd_log2 = 5'd5;
    bar_read(2'd0, d); check("R2 mem size floor 4K", d, hi_ones(12));
    fwd_log2 = 5'd16;
    bar_write(2'd3, 32'h1234_5678);
    bar_read(2'd3, d); check("R1 sel 3 reads zero", d, 32'h0);
    bar_read(2'd0, d); check("R1 sel 3 write ignored", d, hi_ones(16));
  endtask

  task automatic t_io_sizing();
    logic [31:0] d;
    bar_write(2'd1, 32'hFFFF_FFFF);
    bar_read(2'd1, d); check("R3 io size", d, 32'hFFFF_FF01);
  endtask

  task automatic t_rom_sizing();
    logic [31:0] d;
    bar_write(2'd2, 32'hFFFF_FFFF);
    rom_code = 4'd1;
    bar_read(2'd2, d); check("R4 rom 4K", d, hi_ones(12) | 32'h1);
    rom_code = 4'd3;
    bar_read(2'd2, d); check("R4 rom 16K", d, hi_ones(14) | 32'h1);
    rom_code = 4'd13;
    bar_read(2'd2, d); check("R4 rom 16M", d, hi_ones(24) | 32'h1);
  endtask

  task automatic t_rom_absent();
    logic [31:0] d;
    logic [2:0]  h;
    logic [31:0] o;
    bar_write(2'd2, 32'h4000_0001);
    mem_en = 1'b1;
    rom_code = 4'd0;
    bar_read(2'd2, d); check("R5 rom code 0 reads zero", d, 32'h0);
    probe(32'h4000_0100, 1'b0, h, o); check("R5 rom code 0 no hit", {29'h0, h}, 32'h0);
    rom_code = 4'd14;
    bar_read(2'd2, d); check("R5 rom code 14 reads zero", d, 32'h0);
    probe(32'h4000_0100, 1'b0, h, o); check("R5 rom code 14 no hit", {29'h0, h}, 32'h0);
  endtask

  task automatic t_mem_decode();
    logic [2:0]  h;
    logic [31:0] o;
    fwd_log2 = 5'd16; mem_en = 1'b1;
    bar_write(2'd0, 32'h8000_0000);
    probe(32'h8000_0010, 1'b0, h, o);
    check("R6 reg region hit", {29'h0, h}, 32'h4); check("R6 reg offset", o, 32'h10);
    probe(32'h8000_0FFF, 1'b0, h, o);
    check("R6 last reg byte", {29'h0, h}, 32'h4); check("R6 last reg off", o, 32'hFFF);
    probe(32'h8000_1000, 1'b0, h, o);
    check("R7 first fwd byte", {29'h0, h}, 32'h2); check("R7 fwd off edge", o, 32'h1000);
    probe(32'h8000_2345, 1'b0, h, o);
    check("R7 fwd hit", {29'h0, h}, 32'h2); check("R7 fwd offset", o, 32'h2345);
    probe(32'h8001_0000, 1'b0, h, o);
    check("R12 outside miss", {29'h0, h}, 32'h0); check("R12 miss off zero", o, 32'h0);
  endtask

  task automatic t_io_decode();
    logic [2:0]  h;
    logic [31:0] o;
    io_en = 1'b1;
    bar_write(2'd1, 32'h0000_1200);
    probe(32'h0000_1234, 1'b1, h, o);
    check("R8 io hit", {29'h0, h}, 32'h4); check("R8 io offset", o, 32'h34);
    probe(32'h0000_1334, 1'b1, h, o); check("R8 io miss", {29'h0, h}, 32'h0);
  endtask

  task automatic t_rom_decode();
    logic [2:0]  h;
    logic [31:0] o;
    rom_code = 4'd3;
    bar_write(2'd2, 32'h4000_0001);
    probe(32'h4000_3ABC, 1'b0, h, o);
    check("R9 rom hit", {29'h0, h}, 32'h1); check("R9 rom offset", o, 32'h3ABC);
    probe(32'h4000_4000, 1'b0, h, o); check("R9 past rom end", {29'h0, h}, 32'h0);
    bar_write(2'd2, 32'h4000_0000);
    probe(32'h4000_3ABC, 1'b0, h, o); check("R9 enable bit clear", {29'h0, h}, 32'h0);
  endtask

  task automatic t_gating();
    logic [2:0]  h;
    logic [31:0] o;
    mem_en = 1'b0;
    probe(32'h8000_0010, 1'b0, h, o); check("R10 mem off", {29'h0, h}, 32'h0);
    mem_en = 1'b1; io_en = 1'b0;
    probe(32'h0000_1234, 1'b1, h, o); check("R10 io off", {29'h0, h}, 32'h0);
    io_en = 1'b1;
    probe(32'h8000_0010, 1'b1, h, o); check("R10 io space misses mem bar", {29'h0, h}, 32'h0);
  endtask

  task automatic t_overlap();
    logic [2:0]  h;
    logic [31:0] o;
    rom_code = 4'd3;
    bar_write(2'd2, 32'h8000_0001);
    probe(32'h8000_0100, 1'b0, h, o);
    check("R11 mem beats rom", {29'h0, h}, 32'h4); check("R11 overlap off", o, 32'h100);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem_sizing();
    t_io_sizing();
    t_rom_sizing();
    t_rom_absent();
    t_mem_decode();
    t_io_decode();
    t_rom_decode();
    t_gating();
    t_overlap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule